// File: doc/BRIEF.md
# UART Receive FIFO Controller with Character Timeout

This block sits between a UART's serial receiver and the host register interface and manages received bytes. In FIFO mode it stores up to `DEPTH` bytes in arrival order. In single-byte mode it keeps one holding byte. The host reads the head byte through the receive-buffer port. The block keeps the data-ready, overrun and break status flags, and clears break and overrun when the host reads line status.

A FIFO control write selects between the two modes and sets the receive trigger level. The same write can flush the receive storage and can ask a neighbouring transmit block to flush its own storage. Any change of the enable bit forces both flushes.

A character-timeout counter advances on an external one-character-time tick. It raises a pending flag when `TMO_CHARS` character times pass with no arrival and no read while bytes are still held. The host combines the pending flag, `trig_hit`, `iir_fifo_bits` and the status flags into its interrupt identification.

Top module: `rx_fifo_ctl`

## Requirements
- R1: After reset the block is in single-byte mode, the stored control value is 0x00, `fifo_count` is 0, data-ready, overrun, break and timeout-pending are all 0, `trig_level` is 1 and `iir_fifo_bits` is 00.
- R2: A control write stores the data ANDed with 0xC9. Bit 0 enables FIFO mode, and `iir_fifo_bits` then reads 11 (00 otherwise). Bits 7:6 set `trig_level`: code 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R3: In FIFO mode bytes are read back in arrival order. `rbr_data` shows the oldest byte, and each read removes it. A read while the FIFO is empty returns 0x00.
- R4: In FIFO mode, a byte that arrives while the FIFO holds `DEPTH` bytes is discarded, overrun is set, and the stored bytes and count stay unchanged.
- R5: Every arrival sets data-ready. In FIFO mode, a read that empties the FIFO clears both data-ready and break.
- R6: A break event stores a 0x00 byte, as an ordinary arrival does, and sets break and data-ready.
- R7: A line-status read clears break and overrun and leaves the stored bytes and data-ready unchanged.
- R8: A control write with bit 1 set empties the receive FIFO. It clears data-ready, break and timeout-pending, and stops the timeout counter. Overrun is kept.
- R9: A control write that changes bit 0 acts as if bits 1 and 2 were also set. `tx_flush` is high during any control write that has bit 2 set or that changes bit 0.
- R10: In FIFO mode each arrival or read restarts the timeout at `TMO_CHARS` ticks. When the timeout expires, timeout-pending is set only if the FIFO still holds at least one byte.
- R11: A read in FIFO mode clears timeout-pending.
- R12: In single-byte mode an arrival replaces the holding byte. If data-ready was already set, overrun is set. A read returns the holding byte and clears data-ready and break.
- R13: `trig_hit` is high when data-ready is set and the block is either in single-byte mode or holds at least `trig_level` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_data | input | 8 | FIFO control write data |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | W | Received byte |
| rx_break | input | 1 | Break event strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| char_tick | input | 1 | One-character-time tick |
| rbr_data | output | W | Byte returned by a receive buffer read |
| data_ready | output | 1 | Data-ready status |
| overrun | output | 1 | Overrun status |
| brk | output | 1 | Break status |
| timeout_pending | output | 1 | Character timeout pending |
| fifo_en | output | 1 | FIFO mode active |
| fifo_count | output | $clog2(DEPTH+1) | Bytes held in the FIFO |
| trig_level | output | $clog2(DEPTH) | Decoded trigger level in bytes |
| trig_hit | output | 1 | Receive-data interrupt condition |
| iir_fifo_bits | output | 2 | Upper interrupt identification bits |
| fcr_value | output | 8 | Retained control bits |
| tx_flush | output | 1 | Transmit FIFO flush request |

## Verification
Directed sequences fill the FIFO up to the trigger level and then past it, which separates the `trig_hit` threshold from the full-FIFO overrun that discards the extra byte. Other sequences place a read between ticks, to confirm that a read restarts the timeout, and let the timeout expire on an empty FIFO, to confirm that no pending flag appears. Further directed cases flip the enable bit while bytes are held, issue a flush without a toggle, and send back-to-back arrivals in single-byte mode; together they separate toggle-forced flushes, explicit flushes and replace-on-overrun. A long seeded random mix of arrivals, breaks, reads, status reads, ticks and control writes then checks every output against a reference model after each step.

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl #(
  parameter int W         = 8,
  parameter int DEPTH     = 16,
  parameter int TMO_CHARS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fcr_wr,
  input  logic [7:0]                 fcr_data,
  input  logic                       rx_valid,
  input  logic [W-1:0]               rx_byte,
  input  logic                       rx_break,
  input  logic                       rbr_rd,
  input  logic                       lsr_rd,
  input  logic                       char_tick,
  output logic [W-1:0]               rbr_data,
  output logic                       data_ready,
  output logic                       overrun,
  output logic                       brk,
  output logic                       timeout_pending,
  output logic                       fifo_en,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic [$clog2(DEPTH)-1:0]   trig_level,
  output logic                       trig_hit,
  output logic [1:0]                 iir_fifo_bits,
  output logic [7:0]                 fcr_value,
  output logic                       tx_flush
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(TMO_CHARS+1);
  localparam logic [7:0] KEEP_MASK = 8'hC9;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [TW-1:0] TLAST = TW'(TMO_CHARS-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [W-1:0]  hold;
  logic [7:0]    fcr_q;
  logic          dr, oe, bi, pend, trun;
  logic [TW-1:0] tcnt;

  wire toggle  = fcr_wr & (fcr_data[0] ^ fcr_q[0]);
  wire rx_rst  = fcr_wr & (fcr_data[1] | toggle);
  wire fen     = fcr_q[0];
  wire arrive  = ~fcr_wr & (rx_valid | rx_break);
  wire rd      = ~fcr_wr & rbr_rd;
  wire [W-1:0] in_byte = rx_break ? '0 : rx_byte;
  wire push_ok = fen & arrive & (cnt != FULL);
  wire pop_ok  = fen & rd & (cnt != '0);
  wire ovf     = arrive & (fen ? (cnt == FULL) : dr);
  wire empties = rd & (~fen | (cnt <= CW'(1)));

  always_comb begin
    unique case (fcr_q[7:6])
      2'b00:   trig_level = AW'(1);
      2'b01:   trig_level = AW'(DEPTH/4);
      2'b10:   trig_level = AW'(DEPTH/2);
      default: trig_level = AW'(DEPTH-2);
    endcase
  end

  assign tx_flush        = fcr_wr & (fcr_data[2] | toggle);
  assign rbr_data        = fen ? ((cnt != '0) ? mem[rp] : '0) : hold;
  assign data_ready      = dr;
  assign overrun         = oe;
  assign brk             = bi;
  assign timeout_pending = pend;
  assign fifo_en         = fen;
  assign fifo_count      = cnt;
  assign fcr_value       = fcr_q;
  assign iir_fifo_bits   = {2{fen}};
  assign trig_hit        = dr & (~fen | (cnt >= CW'(trig_level)));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q <= '0;
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      hold  <= '0;
      dr    <= 1'b0;
      oe    <= 1'b0;
      bi    <= 1'b0;
    end else if (rx_rst) begin
      fcr_q <= fcr_data & KEEP_MASK;
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      dr    <= 1'b0;
      bi    <= 1'b0;
    end else begin
      if (fcr_wr) fcr_q <= fcr_data & KEEP_MASK;
      if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      if (arrive & ~fen) hold <= in_byte;
      if (arrive)       dr <= 1'b1;
      else if (empties) dr <= 1'b0;
      if (arrive & rx_break)     bi <= 1'b1;
      else if (empties | lsr_rd) bi <= 1'b0;
      if (ovf)         oe <= 1'b1;
      else if (lsr_rd) oe <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      trun <= 1'b0;
      tcnt <= '0;
    end else if (rx_rst) begin
      pend <= 1'b0;
      trun <= 1'b0;
      tcnt <= '0;
    end else begin
      if (fen & rd) pend <= 1'b0;
      if (fen & (arrive | rd)) begin
        trun <= 1'b1;
        tcnt <= '0;
      end else if (char_tick & trun) begin
        if (tcnt == TLAST) begin
          trun <= 1'b0;
          if (cnt != '0) pend <= 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_fifo_ctl_chk.sv
module rx_fifo_ctl_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fcr_wr,
  input logic [7:0]                 fcr_data,
  input logic                       rx_valid,
  input logic                       rx_break,
  input logic                       rbr_rd,
  input logic                       data_ready,
  input logic                       overrun,
  input logic                       brk,
  input logic                       timeout_pending,
  input logic                       fifo_en,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
  localparam int CW = $clog2(DEPTH+1);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && fifo_count == CW'(DEPTH) && rx_valid && !fcr_wr && !rbr_rd
    |=> overrun && fifo_count == CW'(DEPTH));

  assert_rx_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr && fcr_data[1] |=> fifo_count == '0 && !data_ready && !timeout_pending);

  assert_read_clears_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && rbr_rd && !fcr_wr |=> !timeout_pending);

  assert_pend_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pending |-> fifo_count != '0);

  assert_ready_tracks_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> data_ready == (fifo_count != '0));

  assert_break_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break && !fcr_wr |=> brk && data_ready);
endmodule

bind rx_fifo_ctl rx_fifo_ctl_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_data(fcr_data),
  .rx_valid(rx_valid), .rx_break(rx_break), .rbr_rd(rbr_rd),
  .data_ready(data_ready), .overrun(overrun), .brk(brk),
  .timeout_pending(timeout_pending), .fifo_en(fifo_en), .fifo_count(fifo_count)
);

// File: tb/rx_fifo_ctl_tb_top.sv
`timescale 1ns/1ps
module rx_fifo_ctl_tb_top;
  localparam int DEPTH = 16;
  localparam int TMO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcr_wr = 0, rx_valid = 0, rx_break = 0, rbr_rd = 0, lsr_rd = 0, char_tick = 0;
  logic [7:0] fcr_data = '0, rx_byte = '0;
  logic [7:0] rbr_data, fcr_value;
  logic data_ready, overrun, brk, timeout_pending, fifo_en, trig_hit, tx_flush;
  logic [4:0] fifo_count;
  logic [3:0] trig_level;
  logic [1:0] iir_fifo_bits;

  always #2.5 clk = ~clk;

  rx_fifo_ctl #(.W(8), .DEPTH(DEPTH), .TMO_CHARS(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_data(fcr_data),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .char_tick(char_tick),
    .rbr_data(rbr_data), .data_ready(data_ready), .overrun(overrun), .brk(brk),
    .timeout_pending(timeout_pending), .fifo_en(fifo_en), .fifo_count(fifo_count),
    .trig_level(trig_level), .trig_hit(trig_hit), .iir_fifo_bits(iir_fifo_bits),
    .fcr_value(fcr_value), .tx_flush(tx_flush)
  );

  int n_chk = 0;
  int n_err = 0;

  byte unsigned q[$];
  bit m_dr, m_oe, m_bi, m_pend, m_run;
  int m_tc;
  bit [7:0] m_fcr, m_hold;

  function automatic int exp_trig(bit [7:0] f);
    case (f[7:6])
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk("R5", data_ready, m_dr, {tag, " data_ready"});
    chk("R4", overrun, m_oe, {tag, " overrun"});
    chk("R6", brk, m_bi, {tag, " break"});
    chk("R10", timeout_pending, m_pend, {tag, " timeout_pending"});
    chk("R3", fifo_count, q.size(), {tag, " fifo_count"});
    chk("R2", fcr_value, m_fcr, {tag, " fcr_value"});
    chk("R2", fifo_en, m_fcr[0], {tag, " fifo_en"});
    chk("R2", trig_level, exp_trig(m_fcr), {tag, " trig_level"});
    chk("R2", iir_fifo_bits, m_fcr[0] ? 3 : 0, {tag, " iir_fifo_bits"});
    chk("R13", trig_hit, m_dr && (!m_fcr[0] || q.size() >= exp_trig(m_fcr)), {tag, " trig_hit"});
  endtask

  task automatic model(bit v, bit b, bit rd, bit lr, bit fw, bit tk, bit [7:0] d);
    bit arrive;
    bit [7:0] nb;
    if (fw) begin
      bit tog = d[0] ^ m_fcr[0];
      if (d[1] || tog) begin
        q.delete(); m_dr = 0; m_bi = 0; m_pend = 0; m_run = 0;
      end
      m_fcr = d & 8'hC9;
      return;
    end
    arrive = v || b;
    nb = b ? 8'h00 : d;
    if (rd) begin
      if (m_fcr[0]) begin
        if (q.size() > 0) void'(q.pop_front());
        m_pend = 0;
        if (q.size() == 0) begin m_dr = 0; m_bi = 0; end
      end else begin
        m_dr = 0; m_bi = 0;
      end
    end
    if (lr) begin m_bi = 0; m_oe = 0; end
    if (arrive) begin
      if (m_fcr[0]) begin
        if (q.size() == DEPTH) m_oe = 1;
        else q.push_back(nb);
      end else begin
        if (m_dr) m_oe = 1;
        m_hold = nb;
      end
      m_dr = 1;
      if (b) m_bi = 1;
    end
    if (m_fcr[0] && (arrive || rd)) begin
      m_tc = 0; m_run = 1;
    end else if (tk && m_run) begin
      if (m_tc == TMO-1) begin
        m_run = 0;
        if (q.size() > 0) m_pend = 1;
      end else m_tc++;
    end
  endtask

  // Called at a negative edge; returns at the next negative edge.
  task automatic step(bit v, bit b, bit rd, bit lr, bit fw, bit tk, bit [7:0] d, string tag);
    rx_valid = v; rx_break = b; rbr_rd = rd; lsr_rd = lr; fcr_wr = fw; char_tick = tk;
    rx_byte = d; fcr_data = d;
    #1;
    if (rd) chk("R3", rbr_data, m_fcr[0] ? (q.size() > 0 ? q[0] : 0) : m_hold, {tag, " rbr_data"});
    if (fw) chk("R9", tx_flush, d[2] | (d[0] ^ m_fcr[0]), {tag, " tx_flush"});
    @(posedge clk);
    model(v, b, rd, lr, fw, tk, d);
    @(negedge clk);
    rx_valid = 0; rx_break = 0; rbr_rd = 0; lsr_rd = 0; fcr_wr = 0; char_tick = 0;
    compare_all(tag);
  endtask

  task automatic rx(bit [7:0] d, string tag);   step(1, 0, 0, 0, 0, 0, d, tag); endtask
  task automatic rd(string tag);                step(0, 0, 1, 0, 0, 0, 0, tag); endtask
  task automatic tick(string tag);              step(0, 0, 0, 0, 0, 1, 0, tag); endtask
  task automatic fcr(bit [7:0] d, string tag);  step(0, 0, 0, 0, 1, 0, d, tag); endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare_all("R1 reset");

    for (int c = 0; c < 4; c++) fcr(8'h07 | 8'(c << 6), "R2 trigger code");
    fcr(8'hFF, "R2 mask");
    fcr(8'hC1, "R2 trig14");

    for (int i = 0; i < DEPTH; i++) rx(8'h10 + 8'(i), "R13 fill");
    rx(8'hEE, "R4 overflow");
    for (int i = 0; i < DEPTH; i++) rd("R3 order");
    rd("R3 empty read");
    step(0, 0, 0, 1, 0, 0, 0, "R7 lsr read");

    rx(8'h5A, "R7 data");
    step(0, 1, 0, 0, 0, 0, 0, "R6 break");
    step(0, 0, 0, 1, 0, 0, 0, "R7 clear break");
    rd("R5 read");
    step(0, 1, 0, 0, 0, 0, 0, "R6 break again");
    rd("R5 empties");

    rx(8'hA1, "R10 arm");
    for (int i = 0; i < TMO; i++) tick("R10 expire");
    rd("R11 clears pending");
    rx(8'hA2, "R10 b1"); rx(8'hA3, "R10 b2");
    for (int i = 0; i < TMO-1; i++) tick("R10 partial");
    rd("R10 restart");
    for (int i = 0; i < TMO-1; i++) tick("R10 partial2");
    tick("R10 fires");
    rd("R10 empty");
    for (int i = 0; i < TMO+2; i++) tick("R10 no data");

    rx(8'h01, "R8 a"); rx(8'h02, "R8 b"); rx(8'h03, "R8 c");
    for (int i = 0; i < TMO; i++) tick("R8 pend");
    fcr(8'hC3, "R8 flush");
    rx(8'h04, "R9 a"); rx(8'h05, "R9 b");
    fcr(8'h00, "R9 toggle off");
    rx(8'h61, "R12 first");
    rx(8'h62, "R12 second");
    rd("R12 read");
    step(0, 0, 0, 1, 0, 0, 0, "R12 lsr");
    fcr(8'h41, "R9 toggle on");

    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom_range(0, 99));
      bit [7:0] d = 8'($urandom);
      if (sel < 35)      rx(d, "rand rx");
      else if (sel < 58) rd("rand rd");
      else if (sel < 82) tick("rand tick");
      else if (sel < 85) step(0, 1, 0, 0, 0, 0, 0, "rand break");
      else if (sel < 93) step(0, 0, 0, 1, 0, 0, 0, "rand lsr");
      else begin
        if ($urandom_range(0, 9) != 0) d[0] = 1'b1;
        if ($urandom_range(0, 3) != 0) d[1] = 1'b0;
        fcr(d, "rand fcr");
      end
    end
    finish_run();
  end
endmodule